// File: doc/BRIEF.md
# Result-Stationary Systolic Convolver

This block computes a sliding-window convolution, one output per window, with y_i = w1·x_i + w2·x_(i+1) + … + wk·x_(i+k-1). It is built as a chain of k identical cells, one cell per weight. Each cell keeps one output's partial sum in its own accumulator until that output is complete. A small weight store at the head of the chain replays the k weights in order, one per step, and each weight travels one cell per step. Samples travel through two registers per cell, so they move at half the speed of the weights. Because the two streams move at different speeds, every cell meets a new sample/weight pair on every step, and in steady state every cell is busy.

When a cell combines its last weight, it puts the finished sum and that sum's output index on a shared result bus for one cycle. In the same cycle it clears its accumulator, so the next product starts a fresh output. The cells finish on consecutive steps, one after another, so only one cell drives the bus at a time. The whole array advances only on cycles that accept a sample. A run therefore needs samples past the last real window to push the final outputs out, and the delay to an output grows with k.

The array is sized at elaboration: the number of cells equals the number of weights, so a longer filter is built as a longer chain.

Top module: `conv_systolic_rs`

## Requirements
- R1: After k weights are loaded, each result carries res_data = Σ_{t=0..k-1} w_(t+1)·x_(i+t) as a signed two's-complement value, with res_index = i modulo 2^IDX_W. Samples are numbered from 0 after reset.
- R2: With weights 2, 1, 4 and samples 5, 0, -7, 3, 1 followed by padding, outputs 0, 1 and 2 are -18, 5 and -7.
- R3: res_data is ACC_W = DATA_W + WGT_W + ceil(log2 NTAP) + 1 bits wide. Full-scale sums are exact: three products of -128·-128 give 49152.
- R4: At most one result appears per cycle. res_valid is high for exactly one cycle, and only in the cycle right after a rising clock edge that accepted a sample.
- R5: While res_valid is low, res_data and res_index are both zero.
- R6: A cycle with smp_valid low changes no state in the array. Results with idle cycles between samples equal the results without them.
- R7: After reset, res_valid is low. No result is ever produced for a window that would include a sample from before the first one accepted.
- R8: Output y_i appears in the cycle after the sample with index i + k + 2j is accepted, where j = (k − (i mod k)) mod k is the cell that computes it.
- R9: The first wt_valid after reset loads w1, the weight that multiplies x_i. The k-th loads wk, and the (k+1)-th overwrites w1 again, so the latest full set is the one used. Loading happens before the first sample and never in the same cycle as smp_valid.
- R10: From sample index 3k−2 onward, every accepted sample yields exactly one result. After M samples, the number of results equals the number of indices i with i + k + 2j ≤ M − 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| wt_valid | input | 1 | Weight load strobe |
| wt_data | input | WGT_W | Signed weight value being loaded |
| smp_valid | input | 1 | Sample accepted; advances the whole array one step |
| smp_data | input | DATA_W | Signed input sample |
| res_valid | output | 1 | One-cycle strobe marking a finished output |
| res_data | output | ACC_W | Signed convolution result |
| res_index | output | IDX_W | Output index i of the result |

## Verification
The properties assume a full weight set is loaded before the first sample, and that a weight load and a sample never arrive in the same cycle. They also assume that all samples after a reset form one stream, numbered from 0, with fewer than 2^IDX_W entries so that indices never wrap. The stimulus always loads weights first and resets before each new scenario. It inserts idle cycles only between whole samples and keeps every run well under 4096 samples. Each run is padded with extra samples so that the outputs still held in the cells are pushed onto the bus.

// File: rtl/conv_pkg.sv
package conv_pkg;

  // Position markers that travel with every weight along the chain.
  typedef struct packed {
    logic first;
    logic last;
  } tap_tag_t;

  // Modulo increment used by both the replay pointer and the load pointer.
  function automatic int unsigned wrap_next(input int unsigned cur, input int unsigned span);
    return (cur + 1 >= span) ? 0 : cur + 1;
  endfunction

endpackage

// File: rtl/conv_wgt_feed.sv
module conv_wgt_feed
  import conv_pkg::*;
#(
  parameter int NTAP  = 4,
  parameter int WGT_W = 8,
  parameter int IDX_W = 12,
  parameter int PTR_W = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load_en,
  input  logic [WGT_W-1:0] load_data,
  input  logic             adv,
  output logic [WGT_W-1:0] w_emit,
  output tap_tag_t         tag_emit,
  output logic [PTR_W-1:0] tap_ptr,
  output logic [IDX_W-1:0] adv_count
);

  logic [WGT_W-1:0] store [NTAP];
  logic [PTR_W-1:0] load_ptr;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int j = 0; j < NTAP; j++) store[j] <= '0;
      load_ptr <= '0;
    end else if (load_en) begin
      store[load_ptr] <= load_data;
      load_ptr <= PTR_W'(wrap_next(32'(load_ptr), NTAP));
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tap_ptr   <= '0;
      adv_count <= '0;
    end else if (adv) begin
      tap_ptr   <= PTR_W'(wrap_next(32'(tap_ptr), NTAP));
      adv_count <= adv_count + 1'b1;
    end
  end

  always_comb begin
    w_emit         = store[tap_ptr];
    tag_emit.first = (tap_ptr == '0);
    tag_emit.last  = (tap_ptr == PTR_W'(NTAP - 1));
  end

endmodule

// File: rtl/conv_cell.sv
module conv_cell
  import conv_pkg::*;
#(
  parameter int DATA_W  = 8,
  parameter int WGT_W   = 8,
  parameter int ACC_W   = 19,
  parameter int IDX_W   = 12,
  parameter int NTAP    = 4,
  parameter int CELL_ID = 0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              adv,
  input  logic [DATA_W-1:0] x_in,
  input  logic              xv_in,
  input  logic [WGT_W-1:0]  w_in,
  input  tap_tag_t          tag_in,
  input  logic [IDX_W-1:0]  adv_count,
  output logic [DATA_W-1:0] x_out,
  output logic              xv_out,
  output logic [WGT_W-1:0]  w_out,
  output tap_tag_t          tag_out,
  output logic              done,
  output logic [ACC_W-1:0]  res_out,
  output logic [IDX_W-1:0]  idx_out
);

  // Distance from the advance count to the output index this cell finishes.
  localparam int IDX_OFFSET = 2 * CELL_ID + NTAP;

  function automatic logic signed [ACC_W-1:0] mac(
    input logic signed [ACC_W-1:0]  a,
    input logic signed [DATA_W-1:0] x,
    input logic signed [WGT_W-1:0]  w
  );
    logic signed [ACC_W-1:0] xe;
    logic signed [ACC_W-1:0] we;
    xe = ACC_W'(x);
    we = ACC_W'(w);
    return a + xe * we;
  endfunction

  logic [DATA_W-1:0]       xa, xb;
  logic                    xva, xvb;
  logic [WGT_W-1:0]        wr;
  tap_tag_t                tagr;
  logic signed [ACC_W-1:0] acc;
  logic signed [ACC_W-1:0] sum;
  logic                    armed;
  logic                    live;
  logic signed [ACC_W-1:0] res_q;
  logic [IDX_W-1:0]        idx_q;
  logic                    done_q;

  always_comb begin
    sum  = mac(acc, $signed(xa), $signed(wr));
    live = tagr.first ? xva : armed;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      xa     <= '0;
      xb     <= '0;
      xva    <= 1'b0;
      xvb    <= 1'b0;
      wr     <= '0;
      tagr   <= '0;
      acc    <= '0;
      armed  <= 1'b0;
      res_q  <= '0;
      idx_q  <= '0;
      done_q <= 1'b0;
    end else if (adv) begin
      xa     <= x_in;
      xb     <= xa;
      xva    <= xv_in;
      xvb    <= xva;
      wr     <= w_in;
      tagr   <= tag_in;
      armed  <= live;
      acc    <= tagr.last ? '0 : sum;
      done_q <= tagr.last & live;
      if (tagr.last) begin
        res_q <= sum;
        idx_q <= adv_count - IDX_W'(IDX_OFFSET);
      end
    end else begin
      done_q <= 1'b0;
    end
  end

  assign x_out   = xb;
  assign xv_out  = xvb;
  assign w_out   = wr;
  assign tag_out = tagr;
  assign done    = done_q;
  assign res_out = res_q;
  assign idx_out = idx_q;

endmodule

// File: rtl/conv_result_bus.sv
module conv_result_bus #(
  parameter int NTAP  = 4,
  parameter int ACC_W = 19,
  parameter int IDX_W = 12
) (
  input  logic [NTAP-1:0]  done,
  input  logic [ACC_W-1:0] res [NTAP],
  input  logic [IDX_W-1:0] idx [NTAP],
  output logic             bus_valid,
  output logic [ACC_W-1:0] bus_data,
  output logic [IDX_W-1:0] bus_index
);

  always_comb begin
    bus_valid = 1'b0;
    bus_data  = '0;
    bus_index = '0;
    for (int j = 0; j < NTAP; j++) begin
      bus_valid = bus_valid | done[j];
      bus_data  = bus_data  | (done[j] ? res[j] : '0);
      bus_index = bus_index | (done[j] ? idx[j] : '0);
    end
  end

endmodule

// File: rtl/conv_systolic_rs.sv
module conv_systolic_rs
  import conv_pkg::*;
#(
  parameter int NTAP   = 4,
  parameter int DATA_W = 8,
  parameter int WGT_W  = 8,
  parameter int ACC_W  = DATA_W + WGT_W + $clog2(NTAP) + 1,
  parameter int IDX_W  = 12
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wt_valid,
  input  logic [WGT_W-1:0]  wt_data,
  input  logic              smp_valid,
  input  logic [DATA_W-1:0] smp_data,
  output logic              res_valid,
  output logic [ACC_W-1:0]  res_data,
  output logic [IDX_W-1:0]  res_index
);

  localparam int PTR_W = (NTAP > 1) ? $clog2(NTAP) : 1;

  // Named internal events, observed by the bound checker.
  logic             adv;
  logic [PTR_W-1:0] tap_ptr;
  logic [NTAP-1:0]  cell_done;

  logic [IDX_W-1:0]  adv_count;
  logic [DATA_W-1:0] x_link   [NTAP+1];
  logic              xv_link  [NTAP+1];
  logic [WGT_W-1:0]  w_link   [NTAP+1];
  tap_tag_t          tag_link [NTAP+1];
  logic [ACC_W-1:0]  cell_res [NTAP];
  logic [IDX_W-1:0]  cell_idx [NTAP];

  assign adv        = smp_valid;
  assign x_link[0]  = smp_data;
  assign xv_link[0] = 1'b1;

  conv_wgt_feed #(
    .NTAP(NTAP), .WGT_W(WGT_W), .IDX_W(IDX_W), .PTR_W(PTR_W)
  ) u_feed (
    .clk       (clk),
    .rst_n     (rst_n),
    .load_en   (wt_valid),
    .load_data (wt_data),
    .adv       (adv),
    .w_emit    (w_link[0]),
    .tag_emit  (tag_link[0]),
    .tap_ptr   (tap_ptr),
    .adv_count (adv_count)
  );

  for (genvar j = 0; j < NTAP; j++) begin : g_cell
    conv_cell #(
      .DATA_W(DATA_W), .WGT_W(WGT_W), .ACC_W(ACC_W),
      .IDX_W(IDX_W), .NTAP(NTAP), .CELL_ID(j)
    ) u_cell (
      .clk       (clk),
      .rst_n     (rst_n),
      .adv       (adv),
      .x_in      (x_link[j]),
      .xv_in     (xv_link[j]),
      .w_in      (w_link[j]),
      .tag_in    (tag_link[j]),
      .adv_count (adv_count),
      .x_out     (x_link[j+1]),
      .xv_out    (xv_link[j+1]),
      .w_out     (w_link[j+1]),
      .tag_out   (tag_link[j+1]),
      .done      (cell_done[j]),
      .res_out   (cell_res[j]),
      .idx_out   (cell_idx[j])
    );
  end

  conv_result_bus #(
    .NTAP(NTAP), .ACC_W(ACC_W), .IDX_W(IDX_W)
  ) u_bus (
    .done      (cell_done),
    .res       (cell_res),
    .idx       (cell_idx),
    .bus_valid (res_valid),
    .bus_data  (res_data),
    .bus_index (res_index)
  );

endmodule

// File: rtl/conv_systolic_rs_chk.sv
module conv_systolic_rs_chk #(
  parameter int NTAP  = 4,
  parameter int PTR_W = 2,
  parameter int ACC_W = 19,
  parameter int IDX_W = 12
) (
  input logic             clk,
  input logic             rst_n,
  input logic             wt_valid,
  input logic             smp_valid,
  input logic             res_valid,
  input logic [ACC_W-1:0] res_data,
  input logic [IDX_W-1:0] res_index,
  input logic [NTAP-1:0]  cell_done,
  input logic [PTR_W-1:0] tap_ptr
);

  AST_ONE_BUS_DRIVER: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(cell_done)) else $error("two cells drove the bus"); // R4

  AST_RESULT_AFTER_ACCEPT: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid |-> $past(smp_valid)) else $error("result without accepted sample"); // R4

  AST_IDLE_BUS_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    !res_valid |-> (res_data == '0 && res_index == '0)) else $error("idle bus not zero"); // R5

  AST_HOLD_ON_STALL: assert property (@(posedge clk) disable iff (!rst_n)
    !smp_valid |=> $stable(tap_ptr)) else $error("array moved without sample"); // R6

  AST_LOAD_APART: assert property (@(posedge clk) disable iff (!rst_n)
    !(wt_valid && smp_valid)) else $error("weight load during streaming"); // R9

  for (genvar j = 0; j < NTAP; j++) begin : g_sched
    AST_CELL_SCHEDULE: assert property (@(posedge clk) disable iff (!rst_n)
      cell_done[j] |-> ($past(tap_ptr) == PTR_W'(j))) else $error("cell finished off schedule"); // R8
  end

endmodule

bind conv_systolic_rs conv_systolic_rs_chk #(
  .NTAP(NTAP), .PTR_W(PTR_W), .ACC_W(ACC_W), .IDX_W(IDX_W)
) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .wt_valid  (wt_valid),
  .smp_valid (smp_valid),
  .res_valid (res_valid),
  .res_data  (res_data),
  .res_index (res_index),
  .cell_done (cell_done),
  .tap_ptr   (tap_ptr)
);

// File: tb/tb_conv_systolic_rs.sv
module tb_conv_systolic_rs;

  localparam int K  = 3;
  localparam int DW = 8;
  localparam int WW = 8;
  localparam int AW = DW + WW + $clog2(K) + 1;
  localparam int IW = 12;

  typedef struct {
    int idx;
    int val;
  } exp_t;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          wt_valid = 1'b0;
  logic [WW-1:0] wt_data = '0;
  logic          smp_valid = 1'b0;
  logic [DW-1:0] smp_data = '0;
  logic          res_valid;
  logic [AW-1:0] res_data;
  logic [IW-1:0] res_index;

  always #10 clk = ~clk;

  conv_systolic_rs #(
    .NTAP(K), .DATA_W(DW), .WGT_W(WW), .IDX_W(IW)
  ) dut (
    .clk(clk), .rst_n(rst_n), .wt_valid(wt_valid), .wt_data(wt_data),
    .smp_valid(smp_valid), .smp_data(smp_data),
    .res_valid(res_valid), .res_data(res_data), .res_index(res_index)
  );

  int    checks = 0;
  int    errors = 0;
  int    wv [K];
  int    xs [4096];
  int    n_acc = 0;
  int    prev_acc = 0;
  int    n_res = 0;
  bit    mon_on = 1'b0;
  bit    finished = 1'b0;
  string val_tag = "R1";
  exp_t  q [$];
  int    got [16];
  bit    got_seen [16];

  task automatic check(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  function automatic int model(input int i);
    int s = 0;
    for (int t = 0; t < K; t++) s += wv[t] * xs[i + t];
    return s;
  endfunction

  task automatic do_reset();
    mon_on = 1'b0;
    @(negedge clk);
    rst_n = 1'b0; wt_valid = 1'b0; smp_valid = 1'b0;
    q.delete();
    n_acc = 0; prev_acc = 0; n_res = 0;
    for (int i = 0; i < 16; i++) got_seen[i] = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R7: bus quiet after reset
    check(res_valid == 1'b0 && res_data == '0 && res_index == '0, "R7", "reset bus",
          longint'(res_valid), 0);
    mon_on = 1'b1;
  endtask

  task automatic load_set(input int a, input int b, input int c);
    int v [K];
    v[0] = a; v[1] = b; v[2] = c;
    for (int t = 0; t < K; t++) begin
      @(negedge clk);
      wt_valid = 1'b1;
      wt_data  = v[t][WW-1:0];
      wv[t]    = v[t];
    end
    @(negedge clk);
    wt_valid = 1'b0;
  endtask

  // Driver: presents one sample and queues the expected item once a window completes.
  task automatic push_sample(input int v);
    exp_t e;
    @(negedge clk);
    smp_valid = 1'b1;
    smp_data  = v[DW-1:0];
    @(posedge clk);
    xs[n_acc] = v;
    n_acc++;
    if (n_acc >= K) begin
      e.idx = n_acc - K;
      e.val = model(n_acc - K);
      q.push_back(e);
    end
  endtask

  task automatic idle(input int n);
    for (int c = 0; c < n; c++) begin
      @(negedge clk);
      smp_valid = 1'b0;
      @(posedge clk);
    end
  endtask

  task automatic end_scenario(input string tag);
    int cnt = 0;
    idle(2);
    for (int i = 0; i + K <= n_acc; i++) begin
      int j = (K - i % K) % K;
      if (i + K + 2 * j <= n_acc - 1) cnt++;
    end
    // R10: every output whose last sample reached its cell was delivered
    check(n_res == cnt, "R10", {tag, " result count"}, n_res, cnt);
  endtask

  // Monitor: pops expected items by index and checks value and arrival cycle.
  int ridx, rval, hit, jc;
  bit accepted;
  always @(negedge clk) begin
    if (rst_n && mon_on) begin
      accepted = (n_acc != prev_acc);
      if (res_valid) begin
        ridx = int'(res_index);
        rval = int'($signed(res_data));
        hit  = -1;
        foreach (q[p]) if (hit < 0 && q[p].idx == ridx) hit = p;
        // R7: no result for a window outside the stream
        check(hit >= 0, "R7", "unexpected result index", ridx, -1);
        if (hit >= 0) begin
          check(rval == q[hit].val, val_tag, "result value", rval, q[hit].val);
          q.delete(hit);
          if (ridx < 16) begin got[ridx] = rval; got_seen[ridx] = 1'b1; end
        end
        jc = (K - ridx % K) % K;
        // R8: arrival right after sample i+k+2j was accepted
        check(n_acc == ridx + K + 2 * jc + 1, "R8", "arrival sample count",
              n_acc, ridx + K + 2 * jc + 1);
        n_res++;
      end else begin
        // R5: idle bus carries zeros
        check(res_data == '0 && res_index == '0, "R5", "idle bus data",
              longint'(res_data), 0);
      end
      if (!accepted)
        check(res_valid == 1'b0, "R4", "result without sample", longint'(res_valid), 0);
      else if (n_acc - 1 >= 3 * K - 2)
        check(res_valid == 1'b1, "R10", "steady-state result", longint'(res_valid), 1);
      prev_acc = n_acc;
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      checks++;
      errors++;
      $display("FAIL R4 watchdog: actual=timeout expected=completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    int seed;
    int ex [5];
    ex[0] = 5; ex[1] = 0; ex[2] = -7; ex[3] = 3; ex[4] = 1;

    // Scenario A: worked example (R1, R2)
    do_reset();
    val_tag = "R1";
    load_set(2, 1, 4);
    for (int i = 0; i < 5; i++) push_sample(ex[i]);
    for (int i = 0; i < 8; i++) push_sample(0);
    end_scenario("example");
    check(got_seen[0] && got[0] == -18, "R2", "y0", got[0], -18);
    check(got_seen[1] && got[1] == 5, "R2", "y1", got[1], 5);
    check(got_seen[2] && got[2] == -7, "R2", "y2", got[2], -7);

    // Scenario B: second load overwrites first set (R9)
    do_reset();
    val_tag = "R9";
    load_set(9, 9, 9);
    load_set(-128, 127, -3);
    seed = 7;
    for (int i = 0; i < 60; i++) begin
      seed = seed * 1103515245 + 12345;
      push_sample(((seed >>> 16) & 255) - 128);
    end
    end_scenario("reload");

    // Scenario C: idle cycles between samples (R6)
    do_reset();
    val_tag = "R6";
    load_set(3, -5, 7);
    seed = 99;
    for (int i = 0; i < 200; i++) begin
      seed = seed * 1103515245 + 12345;
      push_sample(((seed >>> 16) & 255) - 128);
      if (i % 4 == 3) idle(1 + i % 3);
    end
    end_scenario("gaps");

    // Scenario D: full-scale operands (R3)
    do_reset();
    val_tag = "R3";
    load_set(-128, -128, -128);
    for (int i = 0; i < 12; i++) push_sample(-128);
    for (int i = 0; i < 12; i++) push_sample(127);
    end_scenario("full scale");
    check(got_seen[0] && got[0] == 49152, "R3", "max sum", got[0], 49152);

    finished = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule